// File: doc/BRIEF.md
# DDA Window Scaler Address Stepper

This block turns a stream of output-window pixel and line strobes into the source-image coordinate and frame-buffer byte address that a fetch unit should read. Each axis has a fixed-point accumulator with 12 fractional bits. A step of `0x1000` moves the accumulator by exactly one source pixel. The per-axis step is the source size times `0x1000`, divided by the output size minus one. The divisor is forced to 1 when the output size is 0 or 1.

A configuration load latches the source size, the output size, the frame-buffer base address and the pixel depth. It then starts one iterative divider per axis. While the dividers run the block reports busy and ignores the timing strobes. When both dividers have finished, the block captures the steps and becomes ready. A timing generator then drives frame-start, line-start and pixel-advance strobes. The horizontal accumulator restarts at every line. The vertical accumulator restarts at every frame and advances once per new line.

The state machine has four states:
- `ST_IDLE`: nothing loaded since reset.
- `ST_CALC`: the dividers are running.
- `ST_RUN`: the strobes are followed.
- `ST_FAULT`: an unsupported depth was loaded.

Its transitions are:
- *load-accept*: any state to `ST_CALC`, on a load with depth 16 or 32.
- *load-reject*: any state to `ST_FAULT`, on a load with any other depth.
- *divide-done*: `ST_CALC` to `ST_RUN`, once both dividers are idle and no load is present.

Top module: `dda_scaler_stepper`

## Requirements
- R1: After a load, `h_step_o` = floor(src_w × 4096 / d) and `v_step_o` = floor(src_h × 4096 / d). Here d is the matching output size minus 1, or 1 when that output size is 0 or 1.
- R2: A load with a supported depth raises `busy_o` in the next cycle. `busy_o` stays high for exactly STEP_W+1 cycles (25 with the defaults). `ready_o` then rises in the cycle where `busy_o` falls.
- R3: Both accumulators start at zero after a load. `src_x_o` = `src_y_o` = 0 and `addr_o` equals the loaded base address.
- R4: In `ST_RUN` each cycle with `pix_adv_i` high adds `h_step_o` to the horizontal accumulator. `src_x_o` is the accumulator shifted right by 12.
- R5: In `ST_RUN`, `line_start_i` clears the horizontal accumulator and adds `v_step_o` to the vertical one. `frame_start_i` clears both accumulators and takes priority over the vertical advance.
- R6: Each source coordinate is clamped to the latched source size minus 1 (to 0 for size 0). The 24-bit accumulators saturate instead of wrapping.
- R7: `addr_o` = base + `src_y_o` × (src_w × bytes) + `src_x_o` × bytes, modulo 2^32.
- R8: Depth 32 means 4 bytes per pixel and depth 16 means 2 bytes per pixel. `expand_o` is 1 exactly when the latched depth is below 24.
- R9: A load with a depth other than 16 or 32 sets `cfg_err_o` in the next cycle, with `busy_o` and `ready_o` low. A later supported load clears the fault.
- R10: Outside `ST_RUN`, the pixel, line and frame strobes leave `src_x_o` and `src_y_o` unchanged.
- R11: `busy_o` and `ready_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Latch configuration and start the step computation |
| src_w_i | input | CW | Source image width in pixels |
| src_h_i | input | CW | Source image height in lines |
| out_w_i | input | CW | Output window width |
| out_h_i | input | CW | Output window height |
| base_addr_i | input | AW | Frame-buffer start byte address |
| depth_i | input | 6 | Bits per pixel (16 or 32 accepted) |
| frame_start_i | input | 1 | Frame-start strobe |
| line_start_i | input | 1 | Line-start strobe |
| pix_adv_i | input | 1 | Output-pixel advance strobe |
| busy_o | output | 1 | Step computation in progress |
| ready_o | output | 1 | Configured and following strobes |
| cfg_err_o | output | 1 | Unsupported depth loaded |
| expand_o | output | 1 | Colour expansion needed (depth below 24) |
| h_step_o | output | CW+12 | Horizontal DDA increment |
| v_step_o | output | CW+12 | Vertical DDA increment |
| src_x_o | output | CW | Source column |
| src_y_o | output | CW | Source row |
| addr_o | output | AW | Fetch byte address |

## Verification
The checker watches every cycle for four things:
- `busy_o` and `ready_o` are never high together;
- a supported load is followed by busy and an unsupported load by the fault flag;
- outside the running state the coordinates hold still, and after a load both are zero;
- line and frame strobes zero the matching coordinate, and the coordinates stay below the latched sizes.

The exact step values from the divider, the busy length, the accumulation over many pixels and lines, saturation on upscale, and the address arithmetic for both depths can only be shown by the bench's scenarios. Those scenarios compare the outputs against values computed from the formulas.

// File: rtl/dda_scaler_pkg.sv
package dda_scaler_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CALC  = 2'd1,
        ST_RUN   = 2'd2,
        ST_FAULT = 2'd3
    } stepper_state_e;

    localparam int FRAC_BITS = 12;
    localparam int DEPTH_W   = 6;
endpackage

// File: rtl/dda_divider.sv
module dda_divider #(
    parameter int NW = 24,
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [NW-1:0] dividend_i,
    input  logic [DW-1:0] divisor_i,
    output logic          busy_o,
    output logic [NW-1:0] quot_o
);
    localparam int CNTW = $clog2(NW + 1);

    logic [DW:0]     rem_q;
    logic [NW-1:0]   quo_q;
    logic [DW-1:0]   dvs_q;
    logic [CNTW-1:0] cnt_q;
    logic            busy_q;
    logic [DW:0]     trial;
    logic            fits;

    // restoring division: one quotient bit per cycle
    assign trial = {rem_q[DW-1:0], quo_q[NW-1]};
    assign fits  = trial >= {1'b0, dvs_q};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q  <= '0;
            quo_q  <= '0;
            dvs_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
        end else if (start_i) begin
            rem_q  <= '0;
            quo_q  <= dividend_i;
            dvs_q  <= divisor_i;
            cnt_q  <= CNTW'(NW);
            busy_q <= 1'b1;
        end else if (busy_q) begin
            if (fits) begin
                rem_q <= trial - {1'b0, dvs_q};
                quo_q <= {quo_q[NW-2:0], 1'b1};
            end else begin
                rem_q <= trial;
                quo_q <= {quo_q[NW-2:0], 1'b0};
            end
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNTW'(1)) busy_q <= 1'b0;
        end
    end

    assign busy_o = busy_q;
    assign quot_o = quo_q;
endmodule

// File: rtl/dda_axis.sv
module dda_axis #(
    parameter int CW   = 12,
    parameter int FRAC = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear_i,
    input  logic               adv_i,
    input  logic [CW+FRAC-1:0] step_i,
    input  logic [CW-1:0]      size_i,
    output logic [CW-1:0]      coord_o
);
    localparam int SW = CW + FRAC;

    logic [SW-1:0] acc_q;
    logic [SW:0]   sum;
    logic [CW-1:0] int_part;
    logic [CW-1:0] limit;

    assign sum = {1'b0, acc_q} + {1'b0, step_i};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       acc_q <= '0;
        else if (clear_i) acc_q <= '0;
        else if (adv_i)   acc_q <= sum[SW] ? '1 : sum[SW-1:0];
    end

    assign int_part = acc_q[SW-1:FRAC];
    assign limit    = (size_i == '0) ? '0 : size_i - 1'b1;
    assign coord_o  = (int_part > limit) ? limit : int_part;
endmodule

// File: rtl/dda_scaler_stepper.sv
module dda_scaler_stepper
    import dda_scaler_pkg::*;
#(
    parameter int CW = 12,
    parameter int AW = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load_i,
    input  logic [CW-1:0]          src_w_i,
    input  logic [CW-1:0]          src_h_i,
    input  logic [CW-1:0]          out_w_i,
    input  logic [CW-1:0]          out_h_i,
    input  logic [AW-1:0]          base_addr_i,
    input  logic [DEPTH_W-1:0]     depth_i,
    input  logic                   frame_start_i,
    input  logic                   line_start_i,
    input  logic                   pix_adv_i,
    output logic                   busy_o,
    output logic                   ready_o,
    output logic                   cfg_err_o,
    output logic                   expand_o,
    output logic [CW+FRAC_BITS-1:0] h_step_o,
    output logic [CW+FRAC_BITS-1:0] v_step_o,
    output logic [CW-1:0]          src_x_o,
    output logic [CW-1:0]          src_y_o,
    output logic [AW-1:0]          addr_o
);
    localparam int SW = CW + FRAC_BITS;

    stepper_state_e state_q, state_d;

    logic          depth_ok;
    logic          run;
    logic [CW-1:0] cfg_w_q, cfg_h_q;
    logic [AW-1:0] base_q;
    logic [DEPTH_W-1:0] depth_q;
    logic [SW-1:0] step_q [2];
    logic [SW-1:0] quot_w [2];
    logic          div_busy [2];
    logic [CW-1:0] src_sz [2];
    logic [CW-1:0] out_sz [2];
    logic [CW-1:0] cfg_sz [2];
    logic [CW-1:0] coord [2];
    logic          adv [2];
    logic          clr [2];
    logic          divs_idle;
    logic [AW-1:0] bytes_pp;
    logic [AW-1:0] stride;

    assign depth_ok  = (depth_i == DEPTH_W'(32)) || (depth_i == DEPTH_W'(16));
    assign run       = (state_q == ST_RUN);
    assign divs_idle = !div_busy[0] && !div_busy[1];

    assign src_sz[0] = src_w_i;
    assign src_sz[1] = src_h_i;
    assign out_sz[0] = out_w_i;
    assign out_sz[1] = out_h_i;
    assign cfg_sz[0] = cfg_w_q;
    assign cfg_sz[1] = cfg_h_q;

    // strobe decode: axis 0 follows pixels, axis 1 follows lines
    assign adv[0] = run && pix_adv_i;
    assign clr[0] = load_i || (run && (line_start_i || frame_start_i));
    assign adv[1] = run && line_start_i && !frame_start_i;
    assign clr[1] = load_i || (run && frame_start_i);

    for (genvar a = 0; a < 2; a++) begin : g_axis
        logic [CW-1:0] dvs;
        assign dvs = (out_sz[a] <= CW'(1)) ? CW'(1) : out_sz[a] - 1'b1;

        dda_divider #(.NW(SW), .DW(CW)) u_div (
            .clk        (clk),
            .rst_n      (rst_n),
            .start_i    (load_i && depth_ok),
            .dividend_i ({src_sz[a], {FRAC_BITS{1'b0}}}),
            .divisor_i  (dvs),
            .busy_o     (div_busy[a]),
            .quot_o     (quot_w[a])
        );

        dda_axis #(.CW(CW), .FRAC(FRAC_BITS)) u_acc (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear_i (clr[a]),
            .adv_i   (adv[a]),
            .step_i  (step_q[a]),
            .size_i  (cfg_sz[a]),
            .coord_o (coord[a])
        );
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_RUN, ST_FAULT: begin
                if (load_i) state_d = depth_ok ? ST_CALC : ST_FAULT;
            end
            ST_CALC: begin
                if (load_i)         state_d = depth_ok ? ST_CALC : ST_FAULT;
                else if (divs_idle) state_d = ST_RUN;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // configuration and step capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_w_q   <= '0;
            cfg_h_q   <= '0;
            base_q    <= '0;
            depth_q   <= '0;
            step_q[0] <= '0;
            step_q[1] <= '0;
        end else begin
            if (load_i) begin
                cfg_w_q <= src_w_i;
                cfg_h_q <= src_h_i;
                base_q  <= base_addr_i;
                depth_q <= depth_i;
            end
            if (state_q == ST_CALC && !load_i && divs_idle) begin
                step_q[0] <= quot_w[0];
                step_q[1] <= quot_w[1];
            end
        end
    end

    // outputs
    assign bytes_pp = (depth_q == DEPTH_W'(32)) ? AW'(4) : AW'(2);
    assign stride   = AW'(cfg_w_q) * bytes_pp;

    always_comb begin
        busy_o    = (state_q == ST_CALC);
        ready_o   = (state_q == ST_RUN);
        cfg_err_o = (state_q == ST_FAULT);
        expand_o  = (depth_q < DEPTH_W'(24));
        h_step_o  = step_q[0];
        v_step_o  = step_q[1];
        src_x_o   = coord[0];
        src_y_o   = coord[1];
        addr_o    = base_q + AW'(coord[1]) * stride + AW'(coord[0]) * bytes_pp;
    end
endmodule

// File: rtl/dda_stepper_checker.sv
module dda_stepper_checker #(
    parameter int CW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          load_i,
    input logic [5:0]    depth_i,
    input logic          frame_start_i,
    input logic          line_start_i,
    input logic          busy_o,
    input logic          ready_o,
    input logic          cfg_err_o,
    input logic [CW-1:0] src_x_o,
    input logic [CW-1:0] src_y_o,
    input logic [CW-1:0] cfg_w,
    input logic [CW-1:0] cfg_h
);
    logic ok_depth;
    assign ok_depth = (depth_i == 6'd32) || (depth_i == 6'd16);

    assert_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && ready_o));

    assert_busy_on_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i && ok_depth |=> busy_o);

    assert_fault_on_bad_depth_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load_i && !ok_depth |=> cfg_err_o && !busy_o && !ready_o);

    assert_zero_after_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (src_x_o == '0) && (src_y_o == '0));

    assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_o && !load_i |=> $stable(src_x_o) && $stable(src_y_o));

    assert_line_clears_x_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o && line_start_i && !load_i |=> src_x_o == '0);

    assert_frame_clears_y_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o && frame_start_i && !load_i |=> src_y_o == '0);

    assert_clamp_x_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o && (cfg_w != '0) |-> src_x_o < cfg_w);

    assert_clamp_y_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o && (cfg_h != '0) |-> src_y_o < cfg_h);
endmodule

bind dda_scaler_stepper dda_stepper_checker #(.CW(CW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .load_i        (load_i),
    .depth_i       (depth_i),
    .frame_start_i (frame_start_i),
    .line_start_i  (line_start_i),
    .busy_o        (busy_o),
    .ready_o       (ready_o),
    .cfg_err_o     (cfg_err_o),
    .src_x_o       (src_x_o),
    .src_y_o       (src_y_o),
    .cfg_w         (cfg_w_q),
    .cfg_h         (cfg_h_q)
);

// File: tb/dda_scaler_stepper_tb.sv
module dda_scaler_stepper_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 12;
    localparam int AW = 32;
    localparam int SW = CW + 12;

    typedef struct packed {
        logic [11:0] sw;
        logic [11:0] sh;
        logic [11:0] ow;
        logic [11:0] oh;
        logic [5:0]  dep;
        logic [31:0] base;
        logic [11:0] np;
        logic [11:0] nl;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{12'd640,  12'd480, 12'd640, 12'd480, 6'd32, 32'h1000_0000, 12'd10,  12'd5},
        '{12'd320,  12'd240, 12'd640, 12'd480, 6'd16, 32'h0002_0000, 12'd100, 12'd50},
        '{12'd100,  12'd50,  12'd1,   12'd1,   6'd32, 32'h0000_0400, 12'd3,   12'd2},
        '{12'd1366, 12'd768, 12'd683, 12'd384, 6'd16, 32'h8000_0000, 12'd682, 12'd383},
        '{12'd8,    12'd8,   12'd2,   12'd2,   6'd32, 32'hFFFF_FF00, 12'd1,   12'd1},
        '{12'd64,   12'd32,  12'd0,   12'd0,   6'd16, 32'h0000_0000, 12'd5,   12'd5}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_i = 1'b0;
    logic [CW-1:0] src_w_i = '0, src_h_i = '0, out_w_i = '0, out_h_i = '0;
    logic [AW-1:0] base_addr_i = '0;
    logic [5:0]    depth_i = '0;
    logic          frame_start_i = 1'b0, line_start_i = 1'b0, pix_adv_i = 1'b0;
    logic          busy_o, ready_o, cfg_err_o, expand_o;
    logic [SW-1:0] h_step_o, v_step_o;
    logic [CW-1:0] src_x_o, src_y_o;
    logic [AW-1:0] addr_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dda_scaler_stepper #(.CW(CW), .AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .load_i(load_i),
        .src_w_i(src_w_i), .src_h_i(src_h_i), .out_w_i(out_w_i), .out_h_i(out_h_i),
        .base_addr_i(base_addr_i), .depth_i(depth_i),
        .frame_start_i(frame_start_i), .line_start_i(line_start_i), .pix_adv_i(pix_adv_i),
        .busy_o(busy_o), .ready_o(ready_o), .cfg_err_o(cfg_err_o), .expand_o(expand_o),
        .h_step_o(h_step_o), .v_step_o(v_step_o),
        .src_x_o(src_x_o), .src_y_o(src_y_o), .addr_o(addr_o)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint model_step(longint src, longint outsz);
        longint d = (outsz <= 1) ? 1 : outsz - 1;
        return (src * 4096) / d;
    endfunction

    function automatic longint model_coord(longint step, longint n, longint size);
        longint acc = step * n;
        longint ip, lim;
        if (acc > 64'hFF_FFFF) acc = 64'hFF_FFFF;
        ip  = acc >> 12;
        lim = (size == 0) ? 0 : size - 1;
        return (ip > lim) ? lim : ip;
    endfunction

    task automatic do_load(input vec_t v);
        @(negedge clk);
        src_w_i = v.sw; src_h_i = v.sh; out_w_i = v.ow; out_h_i = v.oh;
        depth_i = v.dep; base_addr_i = v.base; load_i = 1'b1;
        @(negedge clk);
        load_i = 1'b0;
    endtask

    task automatic hold_strobe(input int which, input int n);
        if (n > 0) begin
            if (which == 0) pix_adv_i = 1'b1;
            else if (which == 1) line_start_i = 1'b1;
            else begin frame_start_i = 1'b1; line_start_i = 1'b1; end
            repeat (n) @(negedge clk);
            pix_adv_i = 1'b0; line_start_i = 1'b0; frame_start_i = 1'b0;
        end
    endtask

    task automatic wait_busy(output int cycles, output bit overlap);
        cycles = 0;
        overlap = 1'b0;
        while (busy_o && cycles < 200) begin
            if (ready_o) overlap = 1'b1;
            cycles++;
            @(negedge clk);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int cyc;
        bit ovl;
        vec_t bad;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        chk("R11 reset busy", busy_o, 0);
        chk("R11 reset ready", ready_o, 0);
        chk("R9 reset cfg_err", cfg_err_o, 0);
        // R10: strobes before any load do nothing
        hold_strobe(0, 4);
        hold_strobe(1, 3);
        chk("R10 idle x", src_x_o, 0);
        chk("R10 idle y", src_y_o, 0);

        // vector table
        for (int i = 0; i < NVEC; i++) begin
            vec_t v = VECS[i];
            longint hs = model_step(v.sw, v.ow);
            longint vs = model_step(v.sh, v.oh);
            longint bpp = (v.dep == 6'd32) ? 4 : 2;
            longint ex, ey, ea;
            do_load(v);
            wait_busy(cyc, ovl);
            chk("R2 busy length", cyc, SW + 1);
            chk("R11 busy/ready overlap", ovl, 0);
            chk("R2 ready after busy", ready_o, 1);
            chk("R1 h step", h_step_o, hs);
            chk("R1 v step", v_step_o, vs);
            chk("R3 x zero", src_x_o, 0);
            chk("R3 y zero", src_y_o, 0);
            chk("R3 addr base", addr_o, v.base);
            chk("R8 expand", expand_o, (v.dep < 24) ? 1 : 0);
            hold_strobe(2, 1);
            hold_strobe(1, int'(v.nl));
            hold_strobe(0, int'(v.np));
            ex = model_coord(hs, v.np, v.sw);
            ey = model_coord(vs, v.nl, v.sh);
            ea = (v.base + ey * v.sw * bpp + ex * bpp) & 64'hFFFF_FFFF;
            chk("R4 R6 src x", src_x_o, ex);
            chk("R5 R6 src y", src_y_o, ey);
            chk("R7 R8 addr", addr_o, ea);
        end

        // R5: line start mid-line clears x, advances y
        begin
            vec_t v = VECS[0];
            do_load(v);
            wait_busy(cyc, ovl);
            hold_strobe(2, 1);
            hold_strobe(0, 7);
            chk("R4 x before line", src_x_o, 7);
            hold_strobe(1, 1);
            chk("R5 line clears x", src_x_o, 0);
            chk("R5 line advances y", src_y_o, 1);
            hold_strobe(1, 2);
            hold_strobe(2, 1);
            chk("R5 frame clears y", src_y_o, 0);
        end

        // R10: strobes during the computation are ignored
        begin
            vec_t v = VECS[1];
            do_load(v);
            hold_strobe(0, 5);
            hold_strobe(1, 2);
            chk("R10 calc busy", busy_o, 1);
            chk("R10 calc x", src_x_o, 0);
            chk("R10 calc y", src_y_o, 0);
            wait_busy(cyc, ovl);
            chk("R10 x after calc", src_x_o, 0);
            chk("R10 y after calc", src_y_o, 0);
        end

        // R9: unsupported depths
        bad = VECS[0];
        bad.dep = 6'd24;
        do_load(bad);
        chk("R9 err depth24", cfg_err_o, 1);
        chk("R9 ready low", ready_o, 0);
        chk("R9 busy low", busy_o, 0);
        chk("R8 no expand at 24", expand_o, 0);
        hold_strobe(0, 6);
        hold_strobe(1, 3);
        chk("R9 strobes ignored x", src_x_o, 0);
        chk("R9 strobes ignored y", src_y_o, 0);
        bad.dep = 6'd8;
        do_load(bad);
        chk("R9 err depth8", cfg_err_o, 1);
        chk("R8 expand at 8", expand_o, 1);
        do_load(VECS[2]);
        wait_busy(cyc, ovl);
        chk("R9 recovered err", cfg_err_o, 0);
        chk("R9 recovered ready", ready_o, 1);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule